// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Front End

This block is the bus-facing half of a 512-byte serial EEPROM. It watches the two-wire clock and data lines with the system clock, recognises bus START and STOP conditions, and decodes the select byte against a pair of strap inputs. It then runs the write and read transfers of the memory. The data line is open-drain. The block drives it only through an output-enable: when `sda_oe` is high, the line is pulled low.

Received data bytes go one at a time to an external write buffer, each tagged with its 9-bit address. A STOP that closes a write command with at least one data byte raises a one-cycle commit request. The external programming logic then holds `busy_i` high until the cells are written. While `busy_i` is high the block stays deaf, so a master can poll for completion by re-sending the select byte and waiting for an acknowledge. Reads fetch bytes from a combinational memory port addressed by the internal counter.

Top module: `serial_mem_slave`

## Requirements
- R1: After reset `sda_oe`, `wbuf_push` and `wr_start` are low, and the engine is idle until a START.
- R2: A select byte, MSB first, whose bits 7:4 are 1010 and whose bits 3:2 equal `chip_en[1:0]` is acknowledged on the ninth clock. Any other select byte is not acknowledged, and the block then leaves the line released until the next START.
- R3: A START seen in any state abandons the current transfer and restarts select decoding. This includes a START in the middle of a byte and a repeated START.
- R4: In a write command (select bit 0 = 0) the byte after the select byte is the low 8 address bits, and select bit 1 is address bit 8. Every byte is acknowledged. Each data byte is pushed to the write buffer with its address, and the 9-bit counter then advances, wrapping from 0x1FF to 0x000.
- R5: A STOP ending a write command that carried one or more data bytes raises `wr_start` for one cycle. A STOP after only an address byte (a dummy write) does not.
- R6: A read command (select bit 0 = 1) sends the byte at the current counter, MSB first, and the counter advances by one for every byte sent.
- R7: A dummy write followed by a repeated START and a read select returns data from the address loaded by the dummy write.
- R8: A master acknowledge (line low on the ninth clock) after a read byte makes the block send the next byte. The address wraps from 0x1FF to 0x000.
- R9: A master not-acknowledge (line high on the ninth clock) after a read byte releases the line, and further clocks without a START are not answered.
- R10: While `busy_i` is high, START conditions are ignored and no select byte is acknowledged.
- R11: `sda_oe` changes only while the synchronised clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired line, as seen on the pin) |
| sda_oe | output | 1 | High pulls the data line low |
| chip_en | input | 2 | Strap value matched against select bits 3:2 |
| busy_i | input | 1 | Internal programming cycle in progress |
| mem_addr | output | 9 | Current address counter, read port address |
| mem_rdata | input | 8 | Combinational read data at `mem_addr` |
| wbuf_push | output | 1 | One-cycle strobe: a data byte was received |
| wbuf_addr | output | 9 | Address of the pushed byte |
| wbuf_data | output | 8 | Pushed data byte |
| wr_start | output | 1 | One-cycle request to start the programming cycle |

## Verification
The hardest case to reach is acknowledge polling. A select byte has to arrive while the programming cycle is still running, and `busy_i` has to fall in the middle of that byte. To get there, the bench's own model of the programming logic raises `busy_i` for a fixed window when it sees `wr_start`. The master then starts polling at once, so the first select byte is sure to straddle the end of the busy window. A sequential read is then run across the 0x1FF boundary to check that the same bytes come back after the counter wraps.

// File: rtl/sms_pkg.sv
`timescale 1ns/1ps
package sms_pkg;
    localparam int ADDR_W = 9;
    localparam int DATA_W = 8;
    localparam logic [3:0] DEV_ID = 4'b1010;

    typedef enum logic [3:0] {
        ST_IDLE, ST_SEL, ST_SACK, ST_ADDR, ST_AACK,
        ST_WDAT, ST_DACK, ST_RDAT, ST_RACK, ST_SKIP
    } phase_e;

    typedef struct packed {
        phase_e              st;
        logic [3:0]          cnt;
        logic [DATA_W-1:0]   sh;
        logic [ADDR_W-1:0]   addr;
        logic                a8;
        logic                rw;
        logic                oe;
        logic                mack;
        logic                wrote;
        logic                push;
        logic [ADDR_W-1:0]   paddr;
        logic [DATA_W-1:0]   pdata;
        logic                wstart;
    } eng_t;
endpackage

// File: rtl/sms_sync.sv
`timescale 1ns/1ps
module sms_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic lvl,
    output logic prev
);
    logic [STAGES:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d = {pipe_q[STAGES-1:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '1;
        else        pipe_q <= pipe_d;
    end

    assign lvl  = pipe_q[STAGES-1];
    assign prev = pipe_q[STAGES];
endmodule

// File: rtl/sms_engine.sv
`timescale 1ns/1ps
module sms_engine
    import sms_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_lvl,
    input  logic              scl_prev,
    input  logic              sda_lvl,
    input  logic              sda_prev,
    input  logic [1:0]        chip_en,
    input  logic              busy_i,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              sda_oe,
    output logic              wbuf_push,
    output logic [ADDR_W-1:0] wbuf_addr,
    output logic [DATA_W-1:0] wbuf_data,
    output logic              wr_start
);
    eng_t q, d;

    logic scl_rise, scl_fall, start_det, stop_det, sel_hit;

    assign scl_rise  =  scl_lvl & ~scl_prev;
    assign scl_fall  = ~scl_lvl &  scl_prev;
    assign start_det =  scl_lvl & scl_prev &  sda_prev & ~sda_lvl;
    assign stop_det  =  scl_lvl & scl_prev & ~sda_prev &  sda_lvl;
    assign sel_hit   = (q.sh[7:4] == DEV_ID) && (q.sh[3:2] == chip_en) && !busy_i;

    always_comb begin
        d        = q;
        d.push   = 1'b0;
        d.wstart = 1'b0;
        if (stop_det) begin
            d.st     = ST_IDLE;
            d.oe     = 1'b0;
            d.wstart = q.wrote;
            d.wrote  = 1'b0;
        end else if (start_det && !busy_i) begin
            d.st    = ST_SEL;
            d.cnt   = '0;
            d.oe    = 1'b0;
            d.wrote = 1'b0;
        end else begin
            unique case (q.st)
                ST_IDLE, ST_SKIP: ;
                ST_SEL, ST_ADDR, ST_WDAT: begin
                    if (scl_rise) begin
                        d.sh  = {q.sh[6:0], sda_lvl};
                        d.cnt = q.cnt + 4'd1;
                    end else if (scl_fall && q.cnt == 4'd8) begin
                        d.cnt = '0;
                        if (q.st == ST_SEL) begin
                            if (sel_hit) begin
                                d.oe = 1'b1;
                                d.rw = q.sh[0];
                                d.a8 = q.sh[1];
                                d.st = ST_SACK;
                            end else begin
                                d.st = ST_SKIP;
                            end
                        end else if (q.st == ST_ADDR) begin
                            d.addr = {q.a8, q.sh};
                            d.oe   = 1'b1;
                            d.st   = ST_AACK;
                        end else begin
                            d.push  = 1'b1;
                            d.paddr = q.addr;
                            d.pdata = q.sh;
                            d.addr  = q.addr + 9'd1;
                            d.wrote = 1'b1;
                            d.oe    = 1'b1;
                            d.st    = ST_DACK;
                        end
                    end
                end
                ST_SACK: begin
                    if (scl_fall) begin
                        d.cnt = '0;
                        if (q.rw) begin
                            d.sh   = mem_rdata;
                            d.addr = q.addr + 9'd1;
                            d.oe   = ~mem_rdata[7];
                            d.st   = ST_RDAT;
                        end else begin
                            d.oe = 1'b0;
                            d.st = ST_ADDR;
                        end
                    end
                end
                ST_AACK, ST_DACK: begin
                    if (scl_fall) begin
                        d.oe  = 1'b0;
                        d.cnt = '0;
                        d.st  = ST_WDAT;
                    end
                end
                ST_RDAT: begin
                    if (scl_rise) begin
                        d.cnt = q.cnt + 4'd1;
                    end else if (scl_fall) begin
                        if (q.cnt == 4'd8) begin
                            d.oe  = 1'b0;
                            d.cnt = '0;
                            d.st  = ST_RACK;
                        end else begin
                            d.sh = {q.sh[6:0], 1'b1};
                            d.oe = ~q.sh[6];
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        d.mack = ~sda_lvl;
                    end else if (scl_fall) begin
                        if (q.mack) begin
                            d.sh   = mem_rdata;
                            d.addr = q.addr + 9'd1;
                            d.oe   = ~mem_rdata[7];
                            d.cnt  = '0;
                            d.st   = ST_RDAT;
                        end else begin
                            d.st = ST_IDLE;
                        end
                    end
                end
                default: d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign mem_addr  = q.addr;
    assign sda_oe    = q.oe;
    assign wbuf_push = q.push;
    assign wbuf_addr = q.paddr;
    assign wbuf_data = q.pdata;
    assign wr_start  = q.wstart;

    // R11: the line driver moves only in the low half of the bus clock
    p_oe_scl_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (q.oe != $past(q.oe)) |-> !$past(scl_lvl));

    // R9 / R1: an idle engine never holds the line
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE) |-> !q.oe);

    // R10: a busy programming cycle keeps the engine idle
    p_busy_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE && busy_i && !stop_det) |=> (q.st == ST_IDLE));

    // R4: every pushed byte leaves the counter one past its address
    p_push_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        q.push |-> (q.addr == q.paddr + 9'd1));

    // R5: a commit request only follows a bus STOP
    p_commit_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        q.wstart |-> $past(stop_det));

    // R6: fetching the first read byte advances the counter
    p_read_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(q.st) == ST_SACK && q.st == ST_RDAT) |-> (q.addr == $past(q.addr) + 9'd1));
endmodule

// File: rtl/serial_mem_slave.sv
`timescale 1ns/1ps
module serial_mem_slave
    import sms_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic [1:0]        chip_en,
    input  logic              busy_i,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              wbuf_push,
    output logic [ADDR_W-1:0] wbuf_addr,
    output logic [DATA_W-1:0] wbuf_data,
    output logic              wr_start
);
    logic scl_lvl, scl_prev, sda_lvl, sda_prev;

    sms_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
        .clk(clk), .rst_n(rst_n), .din(scl_i), .lvl(scl_lvl), .prev(scl_prev)
    );

    sms_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
        .clk(clk), .rst_n(rst_n), .din(sda_i), .lvl(sda_lvl), .prev(sda_prev)
    );

    sms_engine u_engine (
        .clk(clk), .rst_n(rst_n),
        .scl_lvl(scl_lvl), .scl_prev(scl_prev),
        .sda_lvl(sda_lvl), .sda_prev(sda_prev),
        .chip_en(chip_en), .busy_i(busy_i),
        .mem_rdata(mem_rdata), .mem_addr(mem_addr),
        .sda_oe(sda_oe),
        .wbuf_push(wbuf_push), .wbuf_addr(wbuf_addr), .wbuf_data(wbuf_data),
        .wr_start(wr_start)
    );
endmodule

// File: tb/sim_serial_mem_slave.sv
`timescale 1ns/1ps
module sim_serial_mem_slave;
    localparam int Q        = 10;
    localparam int BUSY_CYC = 300;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [1:0] ce = 2'b10;
    logic       busy = 1'b0;
    logic       sda_oe, wbuf_push, wr_start;
    logic [8:0] mem_addr, wbuf_addr;
    logic [7:0] mem_rdata, wbuf_data;
    logic [7:0] mem [512];
    wire        sda_bus = sda_m & ~sda_oe;

    int n_cmp = 0, n_bad = 0, n_wst = 0, busy_cnt = 0;
    logic prev_oe = 1'b0;
    logic [16:0] exp_q[$];

    always #2.5 clk = ~clk;

    assign mem_rdata = mem[mem_addr];

    serial_mem_slave u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
        .chip_en(ce), .busy_i(busy), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .wbuf_push(wbuf_push), .wbuf_addr(wbuf_addr), .wbuf_data(wbuf_data),
        .wr_start(wr_start)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // per-clock reference: programming-cycle model, push queue, line discipline
    always begin
        @(negedge clk);
        #1;
        if (rst_n) begin
            chk(!(sda_oe != prev_oe && scl_m), "R11 oe moved with clock high", sda_oe, prev_oe);
            if (wbuf_push) begin
                if (exp_q.size() == 0) chk(1'b0, "R4 unexpected push", {wbuf_addr, wbuf_data}, 0);
                else begin
                    logic [16:0] e;
                    e = exp_q.pop_front();
                    chk({wbuf_addr, wbuf_data} == e, "R4 pushed addr/data", {wbuf_addr, wbuf_data}, e);
                end
            end
            if (wr_start) begin n_wst++; busy_cnt = BUSY_CYC; end
            else if (busy_cnt > 0) busy_cnt--;
            busy = (busy_cnt > 0);
        end
        prev_oe = sda_oe;
    end

    task automatic bstart();
        sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
    endtask

    task automatic bstop();
        sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; tick(Q); scl_m = 1'b1; tick(Q); scl_m = 1'b0; tick(Q);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        send_bits(b, 8);
        sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q / 2);
        acked = !sda_bus;
        tick(Q / 2); scl_m = 1'b0; tick(Q);
    endtask

    task automatic recv_byte(input bit mack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(Q); scl_m = 1'b1; tick(Q / 2); b[i] = sda_bus; tick(Q / 2); scl_m = 1'b0;
        end
        tick(2); sda_m = !mack; tick(Q); scl_m = 1'b1; tick(Q); scl_m = 1'b0; tick(2);
        sda_m = 1'b1; tick(Q);
    endtask

    function automatic logic [7:0] sel(input logic [1:0] c, input logic a8, input logic rd);
        return {4'b1010, c, a8, rd};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        bit a;
        logic [7:0] r;
        int polls;
        for (int i = 0; i < 512; i++) mem[i] = 8'((i * 37 + 5) & 8'hFF);

        tick(8);
        chk(sda_oe == 1'b0, "R1 reset oe", sda_oe, 0);
        chk(wbuf_push == 1'b0 && wr_start == 1'b0, "R1 reset strobes", {wbuf_push, wr_start}, 0);
        rst_n = 1'b1;
        tick(5);

        // R2: wrong strap value, then silence until next START
        bstart();
        send_byte(sel(~ce, 1'b0, 1'b0), a);
        chk(!a, "R2 mismatched select acked", a, 0);
        send_byte(8'h00, a);
        chk(!a, "R2 silent after mismatch", a, 0);
        bstop();

        // R3: START in the middle of a byte restarts decoding
        bstart();
        send_bits(8'hA5, 4);
        bstart();
        send_byte(sel(ce, 1'b1, 1'b0), a);
        chk(a, "R3 select after restart", a, 1);

        // R4: write across the top of memory, counter wraps
        send_byte(8'hFE, a);
        chk(a, "R4 address byte ack", a, 1);
        exp_q.push_back({9'h1FE, 8'hA1});
        exp_q.push_back({9'h1FF, 8'hB2});
        exp_q.push_back({9'h000, 8'hC3});
        send_byte(8'hA1, a); chk(a, "R4 data ack 0", a, 1);
        send_byte(8'hB2, a); chk(a, "R4 data ack 1", a, 1);
        send_byte(8'hC3, a); chk(a, "R4 data ack 2", a, 1);
        bstop();
        tick(3);
        chk(n_wst == 1, "R5 commit after write", n_wst, 1);
        chk(exp_q.size() == 0, "R4 all bytes pushed", exp_q.size(), 0);
        mem[9'h1FE] = 8'hA1; mem[9'h1FF] = 8'hB2; mem[9'h000] = 8'hC3;

        // R10: acknowledge polling while programming
        polls = 0;
        a = 1'b0;
        while (!a && polls < 20) begin
            bstart();
            send_byte(sel(ce, 1'b1, 1'b0), a);
            if (polls == 0) chk(!a, "R10 select acked while busy", a, 0);
            polls++;
        end
        chk(a && polls > 1, "R10 poll eventually acked", polls, 2);

        // R7/R8: dummy write, repeated START, sequential read over wrap
        send_byte(8'hFE, a);
        bstart();
        send_byte(sel(ce, 1'b1, 1'b1), a);
        chk(a, "R7 read select ack", a, 1);
        recv_byte(1'b1, r); chk(r == 8'hA1, "R7 random read byte", r, 8'hA1);
        recv_byte(1'b1, r); chk(r == 8'hB2, "R8 sequential byte", r, 8'hB2);
        recv_byte(1'b0, r); chk(r == 8'hC3, "R8 wrap to zero", r, 8'hC3);

        // R9: after NACK, further clocks are not answered
        for (int i = 0; i < 9; i++) begin
            tick(Q); scl_m = 1'b1; tick(Q / 2);
            chk(sda_bus == 1'b1, "R9 line released after nack", sda_bus, 1);
            tick(Q / 2); scl_m = 1'b0;
        end
        tick(Q);
        bstop();
        tick(3);
        chk(n_wst == 1, "R5 no commit after dummy write", n_wst, 1);

        // R6: current-address read continues from the counter
        bstart();
        send_byte(sel(ce, 1'b0, 1'b1), a);
        chk(a, "R6 current read ack", a, 1);
        recv_byte(1'b0, r);
        chk(r == mem[1], "R6 current read byte", r, mem[1]);
        bstop();

        // R2/R8: other strap value, random then sequential read in block 0
        ce = 2'b01;
        tick(Q);
        bstart();
        send_byte(sel(ce, 1'b0, 1'b0), a);
        chk(a, "R2 select with new strap", a, 1);
        send_byte(8'h10, a);
        bstart();
        send_byte(sel(ce, 1'b0, 1'b1), a);
        for (int i = 0; i < 4; i++) begin
            recv_byte(i != 3, r);
            chk(r == mem[16 + i], "R8 sequential block 0", r, mem[16 + i]);
        end
        bstop();
        tick(20);
        finish_run();
    end
endmodule